// File: doc/BRIEF.md
# DRAM Address-Multiplexing Controller

This block sits between a processor and an asynchronous DRAM. The processor presents a full word address, a read/write flag and a request strobe, and holds them until it sees a completion pulse. The controller splits the address into a row part (high bits) and a column part (low bits). It drives the two parts one after the other on a shared address bus. It strobes the row with an active-low RAS and the column with an active-low CAS, and it drives chip select and the read/write line to the memory. Data wires run directly between processor and memory and do not pass through the block.

A timer inside the block raises a refresh demand every `REFRESH_CYC` clock cycles. A pending refresh is served as soon as the controller is idle, before any new request is taken. It never breaks into an access already in progress. Each refresh is a RAS-only cycle on the row held in a refresh row counter, and that counter then steps by one and wraps to zero after the last row.

For reads, the processor may ask for a page-mode burst. The row is opened once, and `BURST_LEN` consecutive column addresses are then applied, each with its own CAS pulse, without selecting the row again.

Top module: `dram_addr_ctrl`

## Requirements
- R1: During and directly after reset, ras_n_o and cas_n_o are 1, cs_o and mfc_o are 0, mem_rw_o is 1, and the first refresh uses row 0.
- R2: For an access, mem_addr_o carries the row field addr_i[ROW_W+COL_W-1:COL_W] (zero-extended) in the cycle where ras_n_o falls and also in the cycle before it.
- R3: Each CAS pulse carries its column address on mem_addr_o in the cycle where cas_n_o falls and in the cycle before it. cas_n_o is 0 only while ras_n_o is 0. A single access uses the column field addr_i[COL_W-1:0].
- R4: cs_o is 1 in every cycle where ras_n_o is 0. At every CAS fall, mem_rw_o equals the request's rw_i (1 = read, 0 = write).
- R5: A request with burst_i = 0 produces exactly one RAS pulse containing exactly one CAS pulse, followed by one mfc_o pulse.
- R6: A read (rw_i = 1) with burst_i = 1 produces BURST_LEN CAS pulses under a single RAS low period. The columns are c, c+1, ... taken modulo 2^COL_W, where c is the column field.
- R7: burst_i is ignored for writes: a write with burst_i = 1 produces exactly one CAS pulse.
- R8: A refresh is a RAS pulse with no CAS pulse. Its row starts at 0, increases by one per refresh and wraps from 2^ROW_W-1 to 0.
- R9: Refresh ends are never more than REFRESH_CYC + 2*BURST_LEN + 8 cycles apart. A pending refresh is served before a new request is accepted, and a refresh never appears inside an access.
- R10: mfc_o is high for exactly one cycle, namely the cycle right after the last CAS strobe cycle, with ras_n_o and cas_n_o both already back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Processor request, held until mfc_o |
| rw_i | input | 1 | 1 = read, 0 = write |
| burst_i | input | 1 | Ask for a page-mode burst (reads only) |
| addr_i | input | ROW_W+COL_W | Full word address |
| mem_addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| cs_o | output | 1 | Chip select to memory |
| mem_rw_o | output | 1 | Read/write to memory |
| mfc_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives random single reads and writes, random page-mode reads and writes that ask for a burst, with random idle gaps between them. Single accesses check that the address is split into row and column correctly. Burst reads check column stepping and the single row activation. Writes with burst_i = 1 check that the burst request is ignored for writes. Directed cases cover columns near the top of their range, which must wrap inside a burst, and the all-zero and all-one addresses. A long idle stretch lets refreshes run back to back, so the bench can tell the refresh row sequence and its wrap apart from refreshes that are pushed aside by traffic.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW_SETUP,
    ST_ROW_STROBE,
    ST_COL_SETUP,
    ST_COL_STROBE,
    ST_DONE,
    ST_REF_SETUP,
    ST_REF_STROBE,
    ST_REF_END
  } seq_state_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addr_sel_t;
endpackage

// File: rtl/dac_refresh_sched.sv
module dac_refresh_sched #(
  parameter int ROW_W       = 12,
  parameter int REFRESH_CYC = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done_i,
  output logic             due_o,
  output logic [ROW_W-1:0] ref_row_o
);
  localparam int TMR_W = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REFRESH_CYC - 1);

  logic [TMR_W-1:0] tmr_q;
  logic             expire;

  assign expire = (tmr_q == TMR_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q     <= '0;
      due_o     <= 1'b0;
      ref_row_o <= '0;
    end else begin
      tmr_q <= expire ? '0 : tmr_q + 1'b1;
      if (expire)          due_o <= 1'b1;
      else if (ref_done_i) due_o <= 1'b0;
      if (ref_done_i) ref_row_o <= ref_row_o + 1'b1;
    end
  end
endmodule

// File: rtl/dac_sequencer.sv
module dac_sequencer
  import dac_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       rw_i,
  input  logic       burst_i,
  input  logic       due_i,
  output seq_state_t state_o,
  output addr_sel_t  sel_o,
  output logic       accept_o,
  output logic       ref_done_o,
  output logic       col_step_o,
  output logic       ras_n_o,
  output logic       cas_n_o,
  output logic       cs_o,
  output logic       mem_rw_o,
  output logic       mfc_o
);
  localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(BURST_LEN - 1);

  seq_state_t        st_q, st_d;
  logic              rw_q, burst_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;

  assign last_beat = !burst_q || (beat_q == BEAT_LAST);

  always_comb begin
    st_d       = st_q;
    accept_o   = 1'b0;
    col_step_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (due_i)      st_d = ST_REF_SETUP;
        else if (req_i) begin
          st_d     = ST_ROW_SETUP;
          accept_o = 1'b1;
        end
      end
      ST_ROW_SETUP:  st_d = ST_ROW_STROBE;
      ST_ROW_STROBE: st_d = ST_COL_SETUP;
      ST_COL_SETUP:  st_d = ST_COL_STROBE;
      ST_COL_STROBE: begin
        if (last_beat) st_d = ST_DONE;
        else begin
          st_d       = ST_COL_SETUP;
          col_step_o = 1'b1;
        end
      end
      ST_DONE:       st_d = ST_IDLE;
      ST_REF_SETUP:  st_d = ST_REF_STROBE;
      ST_REF_STROBE: st_d = ST_REF_END;
      ST_REF_END:    st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rw_q    <= 1'b1;
      burst_q <= 1'b0;
      beat_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) begin
        rw_q    <= rw_i;
        burst_q <= burst_i & rw_i;
        beat_q  <= '0;
      end else if (col_step_o) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_ROW_SETUP, ST_ROW_STROBE: sel_o = SEL_ROW;
      ST_COL_SETUP, ST_COL_STROBE: sel_o = SEL_COL;
      ST_REF_SETUP, ST_REF_STROBE: sel_o = SEL_REF;
      default:                     sel_o = SEL_NONE;
    endcase
  end

  assign state_o    = st_q;
  assign ref_done_o = (st_q == ST_REF_END);
  assign ras_n_o    = !((st_q == ST_ROW_STROBE) || (st_q == ST_COL_SETUP) ||
                        (st_q == ST_COL_STROBE) || (st_q == ST_REF_STROBE));
  assign cas_n_o    = !(st_q == ST_COL_STROBE);
  assign cs_o       = (st_q != ST_IDLE);
  assign mem_rw_o   = ((st_q == ST_COL_SETUP) || (st_q == ST_COL_STROBE) ||
                       (st_q == ST_ROW_SETUP) || (st_q == ST_ROW_STROBE)) ? rw_q : 1'b1;
  assign mfc_o      = (st_q == ST_DONE);
endmodule

// File: rtl/dac_addr_path.sv
module dac_addr_path
  import dac_pkg::*;
#(
  parameter int ROW_W = 12,
  parameter int COL_W = 9,
  parameter int MA_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic [ROW_W+COL_W-1:0] addr_i,
  input  logic                   col_step_i,
  input  addr_sel_t              sel_i,
  input  logic [ROW_W-1:0]       ref_row_i,
  output logic [MA_W-1:0]        mem_addr_o
);
  function automatic logic [ROW_W-1:0] row_field(input logic [ROW_W+COL_W-1:0] a);
    return a[ROW_W+COL_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_field(input logic [ROW_W+COL_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (load_i) begin
      row_q <= row_field(addr_i);
      col_q <= col_field(addr_i);
    end else if (col_step_i) begin
      col_q <= col_q + 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      SEL_ROW: mem_addr_o = MA_W'(row_q);
      SEL_COL: mem_addr_o = MA_W'(col_q);
      SEL_REF: mem_addr_o = MA_W'(ref_row_i);
      default: mem_addr_o = '0;
    endcase
  end
endmodule

// File: rtl/dram_addr_ctrl.sv
module dram_addr_ctrl
  import dac_pkg::*;
#(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 9,
  parameter int REFRESH_CYC = 512,
  parameter int BURST_LEN   = 4,
  localparam int ADDR_W     = ROW_W + COL_W,
  localparam int MA_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              rw_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MA_W-1:0]   mem_addr_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              cs_o,
  output logic              mem_rw_o,
  output logic              mfc_o
);
  seq_state_t       state;
  addr_sel_t        sel;
  logic             ev_accept;
  logic             ev_ref_done;
  logic             ev_col_step;
  logic             ref_due;
  logic [ROW_W-1:0] ref_row;

  dac_refresh_sched #(
    .ROW_W(ROW_W), .REFRESH_CYC(REFRESH_CYC)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_done_i(ev_ref_done),
    .due_o(ref_due), .ref_row_o(ref_row)
  );

  dac_sequencer #(
    .BURST_LEN(BURST_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rw_i(rw_i), .burst_i(burst_i),
    .due_i(ref_due), .state_o(state), .sel_o(sel), .accept_o(ev_accept),
    .ref_done_o(ev_ref_done), .col_step_o(ev_col_step), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .cs_o(cs_o), .mem_rw_o(mem_rw_o), .mfc_o(mfc_o)
  );

  dac_addr_path #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(ev_accept), .addr_i(addr_i),
    .col_step_i(ev_col_step), .sel_i(sel), .ref_row_i(ref_row),
    .mem_addr_o(mem_addr_o)
  );
endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
  parameter int ROW_W       = 12,
  parameter int REFRESH_CYC = 512,
  parameter int BURST_LEN   = 4,
  parameter int MA_W        = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MA_W-1:0]  mem_addr_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             cs_o,
  input logic             mfc_o,
  input logic             ev_accept,
  input logic             ev_ref_done,
  input logic             ref_due,
  input logic [ROW_W-1:0] ref_row
);
  localparam int SLACK = 2 * BURST_LEN + 8;

  int unsigned since_ref;
  always_ff @(posedge clk) begin
    if (!rst_n)           since_ref <= 0;
    else if (ev_ref_done) since_ref <= 0;
    else                  since_ref <= since_ref + 1;
  end

  // R2
  row_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> $stable(mem_addr_o));

  // R3
  col_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n_o) |-> $stable(mem_addr_o));

  // R3
  cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n_o |-> !ras_n_o);

  // R4
  cs_with_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_o |-> cs_o);

  // R10
  mfc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc_o |=> !mfc_o);

  // R10
  mfc_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mfc_o |-> (ras_n_o && cas_n_o && !$past(cas_n_o)));

  // R8
  ref_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ref_done |=> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

  // R9
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !ref_due);

  // R9
  ref_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_ref <= REFRESH_CYC + SLACK);
endmodule

bind dram_addr_ctrl dac_checker #(
  .ROW_W(ROW_W), .REFRESH_CYC(REFRESH_CYC), .BURST_LEN(BURST_LEN), .MA_W(MA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr_o(mem_addr_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .cs_o(cs_o), .mfc_o(mfc_o), .ev_accept(ev_accept),
  .ev_ref_done(ev_ref_done), .ref_due(ref_due), .ref_row(ref_row)
);

// File: tb/tb_dram_addr_ctrl.sv
`timescale 1ns/1ps
module tb_dram_addr_ctrl;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int REF    = 48;
  localparam int BURST  = 4;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int REF_BOUND = REF + 2 * BURST + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, rw = 1'b1, burst = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [MA_W-1:0] mem_addr;
  logic ras_n, cas_n, cs, mem_rw, mfc;

  always #2.5 clk = ~clk;

  dram_addr_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .REFRESH_CYC(REF), .BURST_LEN(BURST)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rw_i(rw), .burst_i(burst), .addr_i(addr),
    .mem_addr_o(mem_addr), .ras_n_o(ras_n), .cas_n_o(cas_n), .cs_o(cs),
    .mem_rw_o(mem_rw), .mfc_o(mfc));

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  function automatic int exp_row(input logic [ADDR_W-1:0] a);
    return int'(a) / (1 << COL_W);
  endfunction
  function automatic int exp_col(input logic [ADDR_W-1:0] a, input int k);
    return (int'(a) % (1 << COL_W) + k) % (1 << COL_W);
  endfunction
  function automatic int exp_beats(input logic r, input logic b);
    return (r && b) ? BURST : 1;
  endfunction

  task automatic chk(input bit ok, input string req_tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req_tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // expected transaction, set by the driver
  logic [ADDR_W-1:0] x_addr;
  logic x_rw, x_burst;
  bit   x_live = 1'b0;

  // pin monitor state
  logic p_ras = 1'b1, p_cas = 1'b1;
  logic [MA_W-1:0] p_addr = '0;
  int row_seen = 0, cas_cnt = 0;
  int cols[16];
  logic rws[16];
  bit acc_ready = 1'b0;
  int acc_row = 0, acc_cnt = 0;
  int exp_ref = 0, last_ref = 0, n_ref = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (rst_n && !done) begin
      if (p_ras && !ras_n) begin
        chk(mem_addr == p_addr, "R2 row setup hold", int'(mem_addr), int'(p_addr));
        chk(cs, "R4 cs at RAS", int'(cs), 1);
        row_seen = int'(mem_addr);
        cas_cnt  = 0;
      end
      if (!cas_n && ras_n) chk(1'b0, "R3 CAS without RAS", int'(ras_n), 0);
      if (p_cas && !cas_n) begin
        chk(mem_addr == p_addr, "R3 col setup hold", int'(mem_addr), int'(p_addr));
        if (cas_cnt < 16) begin
          cols[cas_cnt] = int'(mem_addr);
          rws[cas_cnt]  = mem_rw;
        end
        cas_cnt++;
      end
      if (!p_ras && ras_n) begin
        if (cas_cnt == 0) begin
          chk(row_seen == exp_ref, "R8 refresh row", row_seen, exp_ref);
          if (n_ref > 0)
            chk(cyc - last_ref <= REF_BOUND, "R9 refresh spacing", cyc - last_ref, REF_BOUND);
          else
            chk(cyc <= REF_BOUND + 4, "R9 first refresh", cyc, REF_BOUND + 4);
          chk(!acc_ready, "R9 refresh inside access", int'(acc_ready), 0);
          exp_ref  = (exp_ref + 1) % (1 << ROW_W);
          last_ref = cyc;
          n_ref++;
        end else begin
          acc_ready = 1'b1;
          acc_row   = row_seen;
          acc_cnt   = cas_cnt;
        end
      end
      if (mfc) begin
        chk(!p_ras && ras_n && cas_n, "R10 mfc after strobes", int'(p_ras), 0);
        chk(acc_ready && x_live, "R5 mfc without access", int'(acc_ready), 1);
        if (acc_ready && x_live) begin
          chk(acc_row == exp_row(x_addr), "R2 row value", acc_row, exp_row(x_addr));
          if (x_burst && x_rw)
            chk(acc_cnt == exp_beats(x_rw, x_burst), "R6 burst CAS count", acc_cnt, BURST);
          else if (x_burst)
            chk(acc_cnt == 1, "R7 write burst ignored", acc_cnt, 1);
          else
            chk(acc_cnt == 1, "R5 single CAS count", acc_cnt, 1);
          for (int k = 0; k < acc_cnt && k < 16; k++) begin
            chk(cols[k] == exp_col(x_addr, k), (x_burst && x_rw) ? "R6 burst column" : "R3 column",
                cols[k], exp_col(x_addr, k));
            chk(rws[k] == x_rw, "R4 mem_rw at CAS", int'(rws[k]), int'(x_rw));
          end
        end
        acc_ready = 1'b0;
      end
    end
    p_ras  = ras_n;
    p_cas  = cas_n;
    p_addr = mem_addr;
  end

  task automatic txn(input logic [ADDR_W-1:0] a, input logic r, input logic b);
    @(negedge clk);
    x_addr = a; x_rw = r; x_burst = b; x_live = 1'b1;
    addr = a; rw = r; burst = b; req = 1'b1;
    do @(negedge clk); while (!mfc);
    req = 1'b0;
    #0.1 x_live = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    idle(3);
    // R1 reset state
    chk(ras_n && cas_n, "R1 strobes in reset", int'({ras_n, cas_n}), 3);
    chk(!cs && !mfc, "R1 cs/mfc in reset", int'({cs, mfc}), 0);
    chk(mem_rw, "R1 mem_rw in reset", int'(mem_rw), 1);
    rst_n = 1'b1;
    idle(1);
    chk(ras_n && cas_n && !cs && !mfc && mem_rw, "R1 after reset",
        int'({ras_n, cas_n, cs, mfc, mem_rw}), 5'b11001);
    // directed corners
    txn('0, 1'b1, 1'b0);
    txn('1, 1'b0, 1'b0);
    txn({{ROW_W{1'b1}}, 3'd6}, 1'b1, 1'b1);   // R6 column wrap 6,7,0,1
    txn({4'd5, 3'd7}, 1'b0, 1'b1);             // R7 write burst ignored
    txn({4'd9, 3'd3}, 1'b1, 1'b1);
    // long idle: back to back refreshes (R8 wrap)
    idle(REF * 18);
    chk(n_ref >= 16, "R8 refresh count for wrap", n_ref, 16);
    // random traffic
    for (int t = 0; t < 150; t++) begin
      txn(ADDR_W'($urandom), 1'($urandom), 1'($urandom));
      idle($urandom_range(0, 5));
    end
    idle(REF * 2);
    done = 1'b1;
    chk(n_ref >= 20, "R9 refreshes kept running", n_ref, 20);
    finish_run();
  end
endmodule